// File: doc/BRIEF.md
# Circular ADC Conversion Sequencer

This block drives a run of voltage conversions over a ring of channel-configuration slots. Software gives a first slot index, a last slot index and a repeat-mode bit, then writes 1 to a start/busy control bit. The sequencer asks an external converter core to convert one slot at a time: it raises a one-cycle request that carries the slot index, waits for the core's done strobe, and forwards the result to the data-buffer entry with the same index.

The slot indices form a ring. The walk always moves upward and wraps from the top slot back to slot 0, so the first index may lie above the last one. In single mode the run ends after the last slot. In repeat mode it goes back to the first slot after the last one, until software writes 0 to the control bit. That stop takes effect only once the conversion in flight has finished. Between two conversions the sequencer shows a slot-boundary window. An external arbiter can hold that window open to fit in a conversion of its own.

Top module: `adc_ring_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `busy`, `conv_req`, `buf_we` and `slot_gap` are all 0, and `slot_done` is all zeros.
- R2: A control write with data 1 while idle captures `cfg_first`, `cfg_last` and `cfg_repeat`. In the next cycle `busy` is 1, `conv_req` is 1 and `conv_slot` equals the captured first index. Later changes to the configuration inputs do not affect the run in progress.
- R3: One pass converts slots first, first+1, … in ascending order modulo 24 and ends with the last slot. A pass therefore holds ((last − first) mod 24) + 1 conversions, and exactly one when first equals last.
- R4: Each conversion starts with `conv_req` high for exactly one cycle. No new request is raised until the core has returned `conv_done` for the current slot.
- R5: In the cycle `conv_done` is high during a conversion, `buf_we` is 1, `buf_addr` equals the slot being converted, `buf_data` equals `conv_result`, and `slot_done` has exactly bit `buf_addr` set. Outside such cycles `buf_we` is 0 and `slot_done` is zero.
- R6: In single mode (`cfg_repeat` = 0), `busy` stays 1 until the last slot's result is written, and it reads 0 in the cycle right after that write.
- R7: In repeat mode (`cfg_repeat` = 1), the slot after the last slot is the first slot again. Passes repeat with `busy` held at 1.
- R8: A control write with data 0 while busy lets the conversion in flight complete and write its result. After that, `busy` falls and no further request is raised. If the write arrives in the slot-boundary window, the sequencer goes idle without a further request.
- R9: A control write with data 1 while `busy` is 1 has no effect: the order, count and configuration of the running sequence are unchanged.
- R10: `slot_gap` is 1 for at least one cycle between two conversions of a run, and `conv_req` is 0 whenever `slot_gap` is 1. While `gap_hold` is 1 during that window, the next request is held back and `slot_gap` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_first | input | 5 | First slot index of the ring walk |
| cfg_last | input | 5 | Last slot index of the ring walk |
| cfg_repeat | input | 1 | 1 = repeat passes, 0 = single pass |
| ctl_wr | input | 1 | Write strobe for the start/busy control bit |
| ctl_wdata | input | 1 | Value written to the control bit |
| busy | output | 1 | Control bit read-back: a run is active |
| conv_req | output | 1 | One-cycle conversion request to the core |
| conv_slot | output | 5 | Slot index being converted |
| conv_done | input | 1 | Core strobe: result is valid |
| conv_result | input | 12 | Conversion result from the core |
| slot_gap | output | 1 | Slot-boundary window between conversions |
| gap_hold | input | 1 | Arbiter request to extend the boundary window |
| buf_we | output | 1 | Data-buffer write enable |
| buf_addr | output | 5 | Data-buffer entry index |
| buf_data | output | 12 | Data-buffer write value |
| slot_done | output | 24 | One-hot per-slot completion pulse |

## Verification
The assertions assume that `cfg_first` and `cfg_last` are always below 24. They also assume that the core raises `conv_done` only while a request is outstanding, and only for one cycle per request. The bench keeps to these limits. Its converter model answers each request once, a fixed 30 cycles later. Every index it drives comes from modulo-24 arithmetic over the full sweep of first indices. The arbiter model raises `gap_hold` only after it has seen `slot_gap`, and it stops by writing the control bit rather than by disturbing the core handshake.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_GAP   = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic write;
        logic advance;
        logic finish;
    } wait_dec_t;

    function automatic int unsigned ring_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    function automatic wait_dec_t decide_wait(logic in_wait, logic done, logic stop_now,
                                              logic at_last, logic rep);
        wait_dec_t d;
        d.write   = in_wait && done;
        d.finish  = d.write && (stop_now || (at_last && !rep));
        d.advance = d.write && !d.finish;
        return d;
    endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_cmd,
    input  logic      stop_cmd,
    input  logic      repeat_in,
    input  logic      conv_done,
    input  logic      at_last,
    input  logic      gap_hold,
    output sq_state_e state,
    output logic      load,
    output logic      step,
    output logic      wr_result
);

    sq_state_e state_q, state_d;
    logic      stop_q, repeat_q;
    logic      stop_now;
    wait_dec_t dec;

    always_comb begin
        stop_now  = stop_q || stop_cmd;
        dec       = decide_wait(state_q == SQ_WAIT, conv_done, stop_now, at_last, repeat_q);
        load      = (state_q == SQ_IDLE) && start_cmd;
        step      = dec.advance;
        wr_result = dec.write;
        state_d   = state_q;
        unique case (state_q)
            SQ_IDLE:  if (start_cmd) state_d = SQ_ISSUE;
            SQ_ISSUE: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (dec.finish)       state_d = SQ_IDLE;
                else if (dec.advance) state_d = SQ_GAP;
            end
            SQ_GAP: begin
                if (stop_now)       state_d = SQ_IDLE;
                else if (!gap_hold) state_d = SQ_ISSUE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            stop_q   <= 1'b0;
            repeat_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                stop_q   <= 1'b0;
                repeat_q <= repeat_in;
            end else if (state_d == SQ_IDLE) begin
                stop_q <= 1'b0;
            end else if (stop_cmd) begin
                stop_q <= 1'b1;
            end
        end
    end

    assign state = state_q;

endmodule

// File: rtl/adc_slot_walker.sv
module adc_slot_walker
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] first_in,
    input  logic [IDX_W-1:0] last_in,
    output logic [IDX_W-1:0] cur,
    output logic             at_last
);

    logic [IDX_W-1:0] cur_q, first_q, last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
        end else if (load) begin
            cur_q   <= first_in;
            first_q <= first_in;
            last_q  <= last_in;
        end else if (step) begin
            if (cur_q == last_q) cur_q <= first_q;
            else                 cur_q <= IDX_W'(ring_next(int'(cur_q), NUM_SLOTS));
        end
    end

    assign cur     = cur_q;
    assign at_last = (cur_q == last_q);

endmodule

// File: rtl/adc_result_writer.sv
module adc_result_writer #(
    parameter int NUM_SLOTS = 24,
    parameter int RES_W     = 12,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                 we_in,
    input  logic [IDX_W-1:0]     idx_in,
    input  logic [RES_W-1:0]     data_in,
    output logic                 buf_we,
    output logic [IDX_W-1:0]     buf_addr,
    output logic [RES_W-1:0]     buf_data,
    output logic [NUM_SLOTS-1:0] slot_done
);

    assign buf_we   = we_in;
    assign buf_addr = idx_in;
    assign buf_data = data_in;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_done
        assign slot_done[g] = we_in && (idx_in == IDX_W'(g));
    end

endmodule

// File: rtl/adc_ring_sequencer.sv
module adc_ring_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 24,
    parameter int RES_W     = 12,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     cfg_first,
    input  logic [IDX_W-1:0]     cfg_last,
    input  logic                 cfg_repeat,
    input  logic                 ctl_wr,
    input  logic                 ctl_wdata,
    output logic                 busy,
    output logic                 conv_req,
    output logic [IDX_W-1:0]     conv_slot,
    input  logic                 conv_done,
    input  logic [RES_W-1:0]     conv_result,
    output logic                 slot_gap,
    input  logic                 gap_hold,
    output logic                 buf_we,
    output logic [IDX_W-1:0]     buf_addr,
    output logic [RES_W-1:0]     buf_data,
    output logic [NUM_SLOTS-1:0] slot_done
);

    sq_state_e        state;
    logic             load, step, wr_result, at_last;
    logic [IDX_W-1:0] cur;

    adc_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (ctl_wr && ctl_wdata),
        .stop_cmd  (ctl_wr && !ctl_wdata),
        .repeat_in (cfg_repeat),
        .conv_done (conv_done),
        .at_last   (at_last),
        .gap_hold  (gap_hold),
        .state     (state),
        .load      (load),
        .step      (step),
        .wr_result (wr_result)
    );

    adc_slot_walker #(.NUM_SLOTS(NUM_SLOTS)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .first_in (cfg_first),
        .last_in  (cfg_last),
        .cur      (cur),
        .at_last  (at_last)
    );

    adc_result_writer #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_wr (
        .we_in     (wr_result),
        .idx_in    (cur),
        .data_in   (conv_result),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data),
        .slot_done (slot_done)
    );

    assign busy      = (state != SQ_IDLE);
    assign conv_req  = (state == SQ_ISSUE);
    assign slot_gap  = (state == SQ_GAP);
    assign conv_slot = cur;

endmodule

// File: rtl/adc_ring_sequencer_chk.sv
module adc_ring_sequencer_chk #(
    parameter int NUM_SLOTS = 24,
    parameter int RES_W     = 12,
    localparam int IDX_W = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 conv_req,
    input logic [IDX_W-1:0]     conv_slot,
    input logic                 conv_done,
    input logic [RES_W-1:0]     conv_result,
    input logic                 slot_gap,
    input logic                 gap_hold,
    input logic                 buf_we,
    input logic [IDX_W-1:0]     buf_addr,
    input logic [RES_W-1:0]     buf_data,
    input logic [NUM_SLOTS-1:0] slot_done
);

    AST_START_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> conv_req); // R2

    AST_SLOT_IN_RING: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(conv_slot) < NUM_SLOTS)); // R3

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req); // R4

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> busy); // R4

    AST_WRITE_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> ($countones(slot_done) == 1 && slot_done[buf_addr] && buf_addr == conv_slot
                    && buf_data == conv_result)); // R5

    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !buf_we |-> (slot_done == '0)); // R5

    AST_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> (conv_done && busy)); // R5

    AST_GAP_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        slot_gap |-> !conv_req); // R10

    AST_GAP_HELD: assert property (@(posedge clk) disable iff (rst)
        (slot_gap && gap_hold) |=> (slot_gap || !busy)); // R10

endmodule

bind adc_ring_sequencer adc_ring_sequencer_chk #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .conv_req    (conv_req),
    .conv_slot   (conv_slot),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .slot_gap    (slot_gap),
    .gap_hold    (gap_hold),
    .buf_we      (buf_we),
    .buf_addr    (buf_addr),
    .buf_data    (buf_data),
    .slot_done   (slot_done)
);

// File: tb/tb_adc_ring_sequencer.sv
`timescale 1ns/1ps
module tb_adc_ring_sequencer;

    localparam int N     = 24;
    localparam int IW    = 5;
    localparam int RW    = 12;
    localparam int CONVT = 30;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] cfg_first = '0, cfg_last = '0;
    logic          cfg_repeat = 1'b0, ctl_wr = 1'b0, ctl_wdata = 1'b0, gap_hold = 1'b0;
    logic          conv_done = 1'b0;
    logic [RW-1:0] conv_result = '0;
    logic          busy, conv_req, slot_gap, buf_we;
    logic [IW-1:0] conv_slot, buf_addr;
    logic [RW-1:0] buf_data;
    logic [N-1:0]  slot_done;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    adc_ring_sequencer dut (
        .clk(clk), .rst(rst), .cfg_first(cfg_first), .cfg_last(cfg_last),
        .cfg_repeat(cfg_repeat), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .busy(busy), .conv_req(conv_req), .conv_slot(conv_slot),
        .conv_done(conv_done), .conv_result(conv_result),
        .slot_gap(slot_gap), .gap_hold(gap_hold), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_data(buf_data), .slot_done(slot_done)
    );

    // converter core model: fixed latency, result = {slot, request tag}
    logic [6:0] tag = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && conv_req) begin
                logic [IW-1:0] s_l;
                s_l = conv_slot;
                repeat (CONVT - 1) @(negedge clk);
                conv_result = {s_l, tag};
                conv_done   = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                tag       = tag + 7'd1;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctl_write(bit v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0; ctl_wdata = 1'b0;
    endtask

    // checks one result write against the expected slot
    task automatic check_write(int exp_slot);
        check(int'(buf_addr) == exp_slot, "R3 slot order", int'(buf_addr), exp_slot);
        check(slot_done == (N'(1) << exp_slot), "R5 one-hot done", int'(slot_done), 1 << exp_slot);
        check(buf_data == conv_result && int'(buf_data[11:7]) == exp_slot,
              "R5 buffer data", int'(buf_data), int'(conv_result));
    endtask

    task automatic run_single(int s, int e);
        int len, n, idle_after;
        len = ((e - s + N) % N) + 1;
        n = 0;
        cfg_first = IW'(s); cfg_last = IW'(e); cfg_repeat = 1'b0;
        ctl_write(1'b1);
        check(busy && conv_req && int'(conv_slot) == s, "R2 start", int'(conv_slot), s);
        idle_after = -1;
        while (busy) begin
            if (buf_we) begin
                check_write((s + n) % N);
                n++;
                idle_after = 0;
            end else if (idle_after >= 0) begin
                idle_after++;
            end
            check(!(slot_gap && conv_req), "R10 gap excludes request", int'(conv_req), 0);
            tick();
        end
        check(n == len, "R3 pass length", n, len);
        check(idle_after == 0, "R6 busy clears after last write", idle_after, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        bit gap_seen;
        // R1 reset state
        repeat (3) tick();
        check(!busy && !conv_req && !buf_we && !slot_gap && slot_done == '0, "R1 in reset",
              int'(busy), 0);
        rst = 1'b0;
        tick();
        check(!busy && !conv_req && !buf_we && !slot_gap && slot_done == '0, "R1 after reset",
              int'(busy), 0);

        // sweep every first index with four ranges: single, pair, full ring, six
        for (int s = 0; s < N; s++) begin
            run_single(s, s);
            run_single(s, (s + 1) % N);
            run_single(s, (s + N - 1) % N);
            run_single(s, (s + 5) % N);
        end

        // R7 repeat mode wrapping across zero, then R8 stop mid-conversion
        cfg_first = 5'd22; cfg_last = 5'd1; cfg_repeat = 1'b1;
        ctl_write(1'b1);
        n = 0;
        while (n < 10) begin
            if (buf_we) begin
                check_write((22 + (n % 4)) % N);
                n++;
            end
            tick();
        end
        check(busy, "R7 still busy after wrap", int'(busy), 1);
        while (!conv_req) tick();
        repeat (5) tick();
        ctl_write(1'b0);
        while (!buf_we) begin
            check(busy, "R8 busy during in-flight", int'(busy), 1);
            tick();
        end
        check_write(0);
        tick();
        check(!busy, "R8 busy falls after in-flight write", int'(busy), 0);
        n = 0;
        repeat (80) begin
            if (conv_req || buf_we) n++;
            tick();
        end
        check(n == 0, "R8 no activity after stop", n, 0);

        // R9 rewrite of 1 while busy is ignored, config changes ignored (R2)
        cfg_first = 5'd3; cfg_last = 5'd6; cfg_repeat = 1'b0;
        ctl_write(1'b1);
        cfg_first = 5'd20; cfg_last = 5'd20; cfg_repeat = 1'b1;
        n = 0;
        while (busy) begin
            if (buf_we) begin
                check_write(3 + n);
                n++;
                if (n == 2) ctl_write(1'b1);
                else tick();
            end else tick();
        end
        check(n == 4, "R9 count unchanged by rewrite", n, 4);

        // R10 arbiter holds the boundary window
        cfg_first = 5'd10; cfg_last = 5'd12; cfg_repeat = 1'b0;
        ctl_write(1'b1);
        gap_seen = 1'b0;
        n = 0;
        while (busy) begin
            if (buf_we) n++;
            if (slot_gap && !gap_seen) begin
                gap_seen = 1'b1;
                gap_hold = 1'b1;
                repeat (8) begin
                    tick();
                    check(slot_gap && !conv_req, "R10 hold keeps window", int'(conv_req), 0);
                end
                gap_hold = 1'b0;
            end
            tick();
        end
        check(gap_seen && n == 3, "R10 run completes after hold", n, 3);

        // R8 stop written inside the boundary window, one-slot ring in repeat mode
        cfg_first = 5'd4; cfg_last = 5'd4; cfg_repeat = 1'b1;
        ctl_write(1'b1);
        n = 0;
        while (!slot_gap) begin
            if (buf_we) begin check_write(4); n++; end
            tick();
        end
        gap_hold = 1'b1;
        ctl_write(1'b0);
        gap_hold = 1'b0;
        check(!busy, "R8 stop in window goes idle", int'(busy), 0);
        repeat (50) begin
            if (conv_req) n++;
            tick();
        end
        check(n == 1, "R8 no request after window stop", n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule